// File: doc/BRIEF.md
# EEPROM Shadow Loader and Validator

This block sits above a serial EEPROM master and keeps a local shadow of a 64-word, 16-bit configuration image. It loads the image lazily. A word lookup that finds no valid signature in the shadow first reads every word from the EEPROM, storing each one and adding it into a wrap-around sum. The block then judges the image by two tests: the magic checksum and the signature field of the init-control word. Once the image is valid, later lookups are served straight from the shadow, with no EEPROM traffic.

The block can also repair the checksum. It sums words 0 to 62 as read from the EEPROM and writes the difference from the magic value into the last word. It can write a single word on behalf of a user. Any write to the EEPROM, including the repair, destroys the shadow signature, so the next lookup reloads the image. The board MAC address and the board-assembly number are assembled from fixed shadow words and read as zero whenever the image is not valid.

Top module: `ee_shadow_ctl`

## Requirements
- R1: A load issues 64 reads to the master at word addresses 0, 1, ..., 63 in ascending order, stores each returned word at its address in the shadow, and adds it into a 16-bit sum that wraps.
- R2: `img_valid` is high only after a load in which the 16-bit sum of all 64 words equals 16'hBABA and bits [15:14] of shadow word 10 equal 2'b01. It is low while a load is in progress.
- R3: When a load's sum differs from 16'hBABA, shadow word 10 is overwritten with 16'h0000 and the image stays invalid, even if the signature bits read from the EEPROM were correct.
- R4: A lookup that finds the image valid is acknowledged with the shadow word and causes no master traffic. A lookup with an in-range index and an invalid image first performs a full load.
- R5: A lookup with an index of 64 or more returns 0 and starts no load. A lookup that still finds the image invalid after its load returns 0.
- R6: The checksum update reads words 0 to 62 from the EEPROM and then writes 16'hBABA minus their 16-bit sum to word 63. `op_done` pulses when the update ends.
- R7: When any EEPROM write completes (a single-word write or the checksum update), the shadow signature is cleared. `img_valid` is low by the time `op_done` pulses, and the next in-range lookup reloads all 64 words.
- R8: `mac_addr` is {w0[7:0], w0[15:8], w1[7:0], w1[15:8], w2[7:0], w2[15:8]}, taken from shadow words 0 to 2, with the first address byte in bits [47:40]. It reads 0 while the image is invalid.
- R9: `pba_num` is {word 9, word 8} of the shadow. It reads 0 while the image is invalid.
- R10: Only one operation runs at a time. `busy` is high from the cycle after a request is accepted until its `lk_ack` or `op_done` pulse ends. Requests are sampled only when idle, with priority lookup, then update, then write. `mem_req` is held with a stable address until `mem_done`.
- R11: After reset, `img_valid`, `busy`, `mem_req`, `mac_addr` and `pba_num` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lk_req | input | 1 | Lookup request, held until `lk_ack` |
| lk_idx | input | 8 | Lookup word index |
| lk_ack | output | 1 | One-cycle lookup completion |
| lk_data | output | 16 | Looked-up word, valid with `lk_ack` |
| upd_req | input | 1 | Checksum-update request, held until `op_done` |
| wr_req | input | 1 | Single-word write request, held until `op_done` |
| wr_addr | input | 6 | Word address to write |
| wr_data | input | 16 | Word to write |
| op_done | output | 1 | One-cycle completion of an update or write |
| busy | output | 1 | An operation is in progress |
| img_valid | output | 1 | Shadow image passed checksum and signature |
| mac_addr | output | 48 | Assembled MAC address, 0 if invalid |
| pba_num | output | 32 | Board-assembly number, 0 if invalid |
| mem_req | output | 1 | Request to the EEPROM master, held until done |
| mem_we | output | 1 | 1 for a write request, 0 for a read |
| mem_addr | output | 6 | EEPROM word address |
| mem_wdata | output | 16 | Word to write |
| mem_done | input | 1 | One-cycle completion from the master |
| mem_rdata | input | 16 | Read data, valid with `mem_done` |

## Verification
The lookup path is driven from three image states: a clean image, one with a single corrupted word, and one whose checksum is correct but whose signature bits read 2'b10. These separate the checksum test from the signature test. Lookups cover a first access that triggers a load, repeated accesses that must not touch the master, and out-of-range indices that must neither load nor return data. Writes and checksum updates are interleaved with lookups to show that each write forces a reload and that the repaired checksum makes the image valid again. A simultaneous update and write show that the priority order is kept.

// File: rtl/ee_shadow_pkg.sv
package ee_shadow_pkg;

    localparam int unsigned EE_WORDS     = 64;
    localparam int unsigned EE_DW        = 16;
    localparam int unsigned EE_IDX_W     = 8;
    localparam int unsigned EE_MAC_WORDS = 3;

    localparam logic [EE_DW-1:0] EE_MAGIC     = 16'hBABA;
    localparam logic [EE_DW-1:0] EE_SIG_MASK  = 16'hC000;
    localparam logic [EE_DW-1:0] EE_SIG_VALID = 16'h4000;
    localparam logic [EE_DW-1:0] EE_SIG_CLEAR = 16'h0000;

    localparam int unsigned EE_ICW_IDX    = 10;
    localparam int unsigned EE_MAC_IDX    = 0;
    localparam int unsigned EE_PBA_LO_IDX = 8;
    localparam int unsigned EE_PBA_HI_IDX = 9;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LOAD,
        S_CHECK,
        S_RESP,
        S_SUMRD,
        S_FIXWR,
        S_WRITE,
        S_DONE
    } ee_state_e;

    function automatic logic sig_match(input logic [EE_DW-1:0] word,
                                       input logic [EE_DW-1:0] mask,
                                       input logic [EE_DW-1:0] pattern);
        return (word & mask) == pattern;
    endfunction

    function automatic logic [EE_DW-1:0] byte_swap(input logic [EE_DW-1:0] w);
        return {w[7:0], w[15:8]};
    endfunction

endpackage

// File: rtl/ee_sum_acc.sv
module ee_sum_acc #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         add,
    input  logic [W-1:0] din,
    output logic [W-1:0] sum
);

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            sum <= '0;
        end else if (add) begin
            sum <= sum + din;
        end
    end

endmodule

// File: rtl/ee_shadow_store.sv
module ee_shadow_store
    import ee_shadow_pkg::*;
#(
    parameter int unsigned      WORDS      = EE_WORDS,
    parameter int unsigned      ICW_IDX    = EE_ICW_IDX,
    parameter int unsigned      MAC_IDX    = EE_MAC_IDX,
    parameter int unsigned      PBA_LO_IDX = EE_PBA_LO_IDX,
    parameter int unsigned      PBA_HI_IDX = EE_PBA_HI_IDX,
    parameter logic [EE_DW-1:0] SIG_MASK   = EE_SIG_MASK,
    parameter logic [EE_DW-1:0] SIG_VALID  = EE_SIG_VALID,
    parameter logic [EE_DW-1:0] SIG_CLEAR  = EE_SIG_CLEAR,
    localparam int unsigned     AW         = $clog2(WORDS),
    localparam int unsigned     MAC_W      = EE_MAC_WORDS * EE_DW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [EE_DW-1:0] wdata,
    input  logic             inval,
    input  logic [AW-1:0]    raddr,
    output logic [EE_DW-1:0] rdata,
    output logic             sig_ok,
    output logic [MAC_W-1:0] mac_raw,
    output logic [31:0]      pba_raw
);

    logic [EE_DW-1:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < WORDS; i++) begin
                mem[i] <= '0;
            end
            mem[ICW_IDX] <= SIG_CLEAR;
        end else if (inval) begin
            mem[ICW_IDX] <= SIG_CLEAR;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata   = mem[raddr];
    assign sig_ok  = sig_match(mem[ICW_IDX], SIG_MASK, SIG_VALID);
    assign pba_raw = {mem[PBA_HI_IDX], mem[PBA_LO_IDX]};

    for (genvar k = 0; k < EE_MAC_WORDS; k++) begin : g_mac
        assign mac_raw[MAC_W-1-EE_DW*k -: EE_DW] = byte_swap(mem[MAC_IDX+k]);
    end

    AST_WRITE_INVAL: assert property (@(posedge clk) disable iff (rst)
        inval |=> !sig_ok) else $error("signature survived invalidation"); // R7

endmodule

// File: rtl/ee_shadow_seq.sv
module ee_shadow_seq
    import ee_shadow_pkg::*;
#(
    parameter int unsigned      WORDS = EE_WORDS,
    parameter int unsigned      IDX_W = EE_IDX_W,
    parameter logic [EE_DW-1:0] MAGIC = EE_MAGIC,
    localparam int unsigned     AW    = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lk_req,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic             upd_req,
    input  logic             wr_req,
    input  logic [AW-1:0]    wr_addr,
    input  logic [EE_DW-1:0] wr_data,
    input  logic             img_ok,
    input  logic [EE_DW-1:0] sum,
    input  logic             mem_done,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [EE_DW-1:0] mem_wdata,
    output logic             st_we,
    output logic [AW-1:0]    st_waddr,
    output logic             inval,
    output logic             acc_clr,
    output logic             acc_add,
    output logic [AW-1:0]    idx_q,
    output logic             oor_q,
    output logic             loading,
    output logic             lk_ack,
    output logic             op_done,
    output logic             busy
);

    localparam logic [AW-1:0]  LAST_W   = AW'(WORDS - 1);
    localparam logic [AW-1:0]  PENULT_W = AW'(WORDS - 2);
    localparam logic [IDX_W:0] LIMIT    = (IDX_W + 1)'(WORDS);

    typedef struct packed {
        logic [AW-1:0]    addr;
        logic [EE_DW-1:0] data;
    } wr_cmd_t;

    ee_state_e     st;
    logic [AW-1:0] cnt;
    wr_cmd_t       wcmd;
    logic          idx_out;

    assign idx_out = {1'b0, lk_idx} >= LIMIT;

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= S_IDLE;
            cnt   <= '0;
            idx_q <= '0;
            oor_q <= 1'b0;
            wcmd  <= '0;
        end else begin
            unique case (st)
                S_IDLE: begin
                    cnt <= '0;
                    if (lk_req) begin
                        idx_q <= lk_idx[AW-1:0];
                        oor_q <= idx_out;
                        st    <= (idx_out || img_ok) ? S_RESP : S_LOAD;
                    end else if (upd_req) begin
                        st <= S_SUMRD;
                    end else if (wr_req) begin
                        wcmd <= '{addr: wr_addr, data: wr_data};
                        st   <= S_WRITE;
                    end
                end
                S_LOAD: begin
                    if (mem_done) begin
                        cnt <= cnt + 1'b1;
                        if (cnt == LAST_W) begin
                            st <= S_CHECK;
                        end
                    end
                end
                S_CHECK: st <= S_RESP;
                S_RESP:  st <= S_IDLE;
                S_SUMRD: begin
                    if (mem_done) begin
                        cnt <= cnt + 1'b1;
                        if (cnt == PENULT_W) begin
                            st <= S_FIXWR;
                        end
                    end
                end
                S_FIXWR: if (mem_done) st <= S_DONE;
                S_WRITE: if (mem_done) st <= S_DONE;
                S_DONE:  st <= S_IDLE;
                default: st <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = cnt;
        mem_wdata = '0;
        unique case (st)
            S_LOAD, S_SUMRD: mem_req = 1'b1;
            S_FIXWR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = LAST_W;
                mem_wdata = MAGIC - sum;
            end
            S_WRITE: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = wcmd.addr;
                mem_wdata = wcmd.data;
            end
            default: ;
        endcase
    end

    assign st_we    = (st == S_LOAD) && mem_done;
    assign st_waddr = cnt;
    assign acc_clr  = (st == S_IDLE);
    assign acc_add  = mem_done && ((st == S_LOAD) || (st == S_SUMRD));
    assign inval    = ((st == S_CHECK) && (sum != MAGIC))
                    || (mem_done && ((st == S_FIXWR) || (st == S_WRITE)));
    assign loading  = (st == S_LOAD) || (st == S_CHECK);
    assign lk_ack   = (st == S_RESP);
    assign op_done  = (st == S_DONE);
    assign busy     = (st != S_IDLE);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_done) |=> mem_req) else $error("request dropped early"); // R10

    AST_ADDR_STABLE: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_done) |=> ($stable(mem_addr) && $stable(mem_we)))
        else $error("request changed before done"); // R10

    AST_LOAD_ORDER: assert property (@(posedge clk) disable iff (rst)
        ((st == S_LOAD) && mem_done && (mem_addr != LAST_W))
        |=> ((st == S_LOAD) && (mem_addr == $past(mem_addr) + 1'b1)))
        else $error("load address out of order"); // R1

endmodule

// File: rtl/ee_shadow_ctl.sv
module ee_shadow_ctl
    import ee_shadow_pkg::*;
#(
    parameter int unsigned      WORDS      = EE_WORDS,
    parameter int unsigned      IDX_W      = EE_IDX_W,
    parameter logic [EE_DW-1:0] MAGIC      = EE_MAGIC,
    parameter int unsigned      ICW_IDX    = EE_ICW_IDX,
    parameter int unsigned      MAC_IDX    = EE_MAC_IDX,
    parameter int unsigned      PBA_LO_IDX = EE_PBA_LO_IDX,
    parameter int unsigned      PBA_HI_IDX = EE_PBA_HI_IDX,
    parameter logic [EE_DW-1:0] SIG_MASK   = EE_SIG_MASK,
    parameter logic [EE_DW-1:0] SIG_VALID  = EE_SIG_VALID,
    parameter logic [EE_DW-1:0] SIG_CLEAR  = EE_SIG_CLEAR,
    localparam int unsigned     AW         = $clog2(WORDS),
    localparam int unsigned     MAC_W      = EE_MAC_WORDS * EE_DW
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lk_req,
    input  logic [IDX_W-1:0] lk_idx,
    output logic             lk_ack,
    output logic [EE_DW-1:0] lk_data,
    input  logic             upd_req,
    input  logic             wr_req,
    input  logic [AW-1:0]    wr_addr,
    input  logic [EE_DW-1:0] wr_data,
    output logic             op_done,
    output logic             busy,
    output logic             img_valid,
    output logic [MAC_W-1:0] mac_addr,
    output logic [31:0]      pba_num,
    output logic             mem_req,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [EE_DW-1:0] mem_wdata,
    input  logic             mem_done,
    input  logic [EE_DW-1:0] mem_rdata
);

    logic             st_we;
    logic [AW-1:0]    st_waddr;
    logic             inval;
    logic             acc_clr;
    logic             acc_add;
    logic [AW-1:0]    idx_q;
    logic             oor_q;
    logic             loading;
    logic             sig_ok;
    logic [EE_DW-1:0] sum;
    logic [EE_DW-1:0] rdata;
    logic [MAC_W-1:0] mac_raw;
    logic [31:0]      pba_raw;

    ee_shadow_seq #(
        .WORDS (WORDS),
        .IDX_W (IDX_W),
        .MAGIC (MAGIC)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .lk_req    (lk_req),
        .lk_idx    (lk_idx),
        .upd_req   (upd_req),
        .wr_req    (wr_req),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .img_ok    (sig_ok),
        .sum       (sum),
        .mem_done  (mem_done),
        .mem_req   (mem_req),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .st_we     (st_we),
        .st_waddr  (st_waddr),
        .inval     (inval),
        .acc_clr   (acc_clr),
        .acc_add   (acc_add),
        .idx_q     (idx_q),
        .oor_q     (oor_q),
        .loading   (loading),
        .lk_ack    (lk_ack),
        .op_done   (op_done),
        .busy      (busy)
    );

    ee_sum_acc #(
        .W (EE_DW)
    ) u_acc (
        .clk (clk),
        .rst (rst),
        .clr (acc_clr),
        .add (acc_add),
        .din (mem_rdata),
        .sum (sum)
    );

    ee_shadow_store #(
        .WORDS      (WORDS),
        .ICW_IDX    (ICW_IDX),
        .MAC_IDX    (MAC_IDX),
        .PBA_LO_IDX (PBA_LO_IDX),
        .PBA_HI_IDX (PBA_HI_IDX),
        .SIG_MASK   (SIG_MASK),
        .SIG_VALID  (SIG_VALID),
        .SIG_CLEAR  (SIG_CLEAR)
    ) u_store (
        .clk     (clk),
        .rst     (rst),
        .we      (st_we),
        .waddr   (st_waddr),
        .wdata   (mem_rdata),
        .inval   (inval),
        .raddr   (idx_q),
        .rdata   (rdata),
        .sig_ok  (sig_ok),
        .mac_raw (mac_raw),
        .pba_raw (pba_raw)
    );

    assign img_valid = sig_ok && !loading;
    assign lk_data   = (lk_ack && !oor_q && img_valid) ? rdata : '0;
    assign mac_addr  = img_valid ? mac_raw : '0;
    assign pba_num   = img_valid ? pba_raw : '0;

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !mem_req) else $error("master traffic while idle"); // R10

endmodule

// File: tb/ee_shadow_ctl_test.sv
`timescale 1ns/1ps
module ee_shadow_ctl_test;

    localparam int LAT = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lk_req = 1'b0;
    logic [7:0]  lk_idx = '0;
    logic        lk_ack;
    logic [15:0] lk_data;
    logic        upd_req = 1'b0;
    logic        wr_req = 1'b0;
    logic [5:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic        op_done;
    logic        busy;
    logic        img_valid;
    logic [47:0] mac_addr;
    logic [31:0] pba_num;
    logic        mem_req;
    logic        mem_we;
    logic [5:0]  mem_addr;
    logic [15:0] mem_wdata;
    logic        mem_done;
    logic [15:0] mem_rdata;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    ee_shadow_ctl uut (
        .clk(clk), .rst(rst),
        .lk_req(lk_req), .lk_idx(lk_idx), .lk_ack(lk_ack), .lk_data(lk_data),
        .upd_req(upd_req), .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
        .op_done(op_done), .busy(busy), .img_valid(img_valid),
        .mac_addr(mac_addr), .pba_num(pba_num),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_done(mem_done), .mem_rdata(mem_rdata)
    );

    // ---------------- EEPROM master model ----------------
    logic [15:0] em [64];
    int          m_st;
    int          m_cnt;
    logic [5:0]  m_addr;
    logic        m_we;
    logic [15:0] m_wd;
    int          rd_cnt;
    int          wr_cnt;
    int          order_bad;
    logic [5:0]  rd_next;
    logic [5:0]  last_wr;

    function automatic logic [15:0] base_word(int i);
        if (i == 10) return 16'h4A5C;
        return 16'(i * 16'h0731 + 16'h1200);
    endfunction

    function automatic logic [15:0] init_word(int i);
        logic [15:0] s;
        if (i != 63) return base_word(i);
        s = '0;
        for (int j = 0; j < 63; j++) s = s + base_word(j);
        return 16'hBABA - s;
    endfunction

    always @(negedge clk) begin
        if (rst) begin
            for (int i = 0; i < 64; i++) em[i] <= init_word(i);
            m_st <= 0; m_cnt <= 0; mem_done <= 1'b0; mem_rdata <= '0;
            rd_cnt <= 0; wr_cnt <= 0; order_bad <= 0; rd_next <= '0; last_wr <= '0;
            m_addr <= '0; m_we <= 1'b0; m_wd <= '0;
        end else begin
            case (m_st)
                0: begin
                    mem_done <= 1'b0;
                    if (mem_req) begin
                        m_addr <= mem_addr; m_we <= mem_we; m_wd <= mem_wdata;
                        m_cnt <= LAT; m_st <= 1;
                    end
                end
                1: begin
                    if (m_cnt == 0) begin
                        mem_done <= 1'b1;
                        if (m_we) begin
                            em[m_addr] <= m_wd;
                            wr_cnt <= wr_cnt + 1;
                            last_wr <= m_addr;
                            rd_next <= '0;
                        end else begin
                            mem_rdata <= em[m_addr];
                            rd_cnt <= rd_cnt + 1;
                            if (m_addr != rd_next) order_bad <= order_bad + 1;
                            rd_next <= m_addr + 1'b1;
                        end
                        m_st <= 2;
                    end else begin
                        m_cnt <= m_cnt - 1;
                    end
                end
                default: begin
                    mem_done <= 1'b0;
                    m_st <= 0;
                end
            endcase
        end
    end

    // ---------------- helpers ----------------
    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] sum63();
        logic [15:0] s = '0;
        for (int j = 0; j < 63; j++) s = s + em[j];
        return s;
    endfunction

    function automatic logic [47:0] exp_mac();
        return {em[0][7:0], em[0][15:8], em[1][7:0], em[1][15:8], em[2][7:0], em[2][15:8]};
    endfunction

    task automatic lookup(input logic [7:0] idx, output logic [15:0] data);
        @(negedge clk);
        lk_req = 1'b1; lk_idx = idx;
        do @(negedge clk); while (!lk_ack);
        data = lk_data;
        lk_req = 1'b0;
    endtask

    task automatic do_write(input logic [5:0] a, input logic [15:0] d);
        @(negedge clk);
        wr_req = 1'b1; wr_addr = a; wr_data = d;
        do @(negedge clk); while (!op_done);
        wr_req = 1'b0;
    endtask

    task automatic do_update();
        @(negedge clk);
        upd_req = 1'b1;
        do @(negedge clk); while (!op_done);
        upd_req = 1'b0;
    endtask

    localparam logic [7:0] LK_TAB [8] = '{8'd3, 8'd0, 8'd10, 8'd63, 8'd64, 8'd200, 8'd37, 8'd2};

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] d;
        logic [15:0] fix;
        int          rd0;
        int          wr0;

        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R11: reset state
        chk(img_valid == 1'b0, "R11 img_valid", img_valid, 0);
        chk(busy == 1'b0 && mem_req == 1'b0, "R11 busy/mem_req", {busy, mem_req}, 0);
        chk(mac_addr == '0 && pba_num == '0, "R11 mac/pba", {mac_addr[31:0], pba_num}, 0);

        // Table of lookups against the clean image; the first one loads (R4, R5)
        foreach (LK_TAB[k]) begin
            logic [15:0] exp;
            exp = (LK_TAB[k] < 8'd64) ? em[LK_TAB[k][5:0]] : 16'h0000;
            lookup(LK_TAB[k], d);
            chk(d == exp, $sformatf("R4/R5 lookup idx %0d", LK_TAB[k]), d, exp);
        end
        chk(rd_cnt == 64, "R4 single lazy load", rd_cnt, 64);
        chk(order_bad == 0, "R1 ascending read order", order_bad, 0);
        chk(img_valid == 1'b1, "R2 clean image valid", img_valid, 1);
        chk(mac_addr == exp_mac(), "R8 mac assembly", mac_addr, exp_mac());
        chk(pba_num == {em[9], em[8]}, "R9 pba assembly", pba_num, {em[9], em[8]});

        // R5: out-of-range lookup on a valid image starts nothing
        rd0 = rd_cnt;
        lookup(8'd64, d);
        chk(d == 16'h0 && rd_cnt == rd0, "R5 out of range no load", {d, 16'(rd_cnt - rd0)}, 0);

        // R7: a single-word write invalidates the shadow
        do_write(6'd5, 16'h1234);
        chk(img_valid == 1'b0, "R7 write clears valid", img_valid, 0);
        chk(em[5] == 16'h1234, "R7 write reached EEPROM", em[5], 16'h1234);
        chk(mac_addr == '0 && pba_num == '0, "R8/R9 zero when invalid", {mac_addr[31:0], pba_num}, 0);

        // R3: checksum now broken -> reload, result invalid, data 0
        rd0 = rd_cnt;
        lookup(8'd5, d);
        chk(rd_cnt - rd0 == 64, "R7 reload after write", rd_cnt - rd0, 64);
        chk(d == 16'h0, "R3 bad checksum lookup zero", d, 0);
        chk(img_valid == 1'b0, "R3 bad checksum invalid", img_valid, 0);

        // R6: checksum update repairs word 63
        fix = 16'hBABA - sum63();
        rd0 = rd_cnt; wr0 = wr_cnt;
        do_update();
        chk(em[63] == fix, "R6 repaired checksum", em[63], fix);
        chk(rd_cnt - rd0 == 63 && wr_cnt - wr0 == 1, "R6 update traffic",
            {32'(rd_cnt - rd0), 32'(wr_cnt - wr0)}, {32'd63, 32'd1});
        lookup(8'd5, d);
        chk(d == 16'h1234 && img_valid, "R2 valid after repair", {img_valid, d}, {1'b1, 16'h1234});

        // R4: a hit makes no traffic
        rd0 = rd_cnt;
        lookup(8'd40, d);
        chk(rd_cnt == rd0 && d == em[40], "R4 hit without traffic", {16'(rd_cnt - rd0), d}, {16'd0, em[40]});

        // R2: good checksum but signature bits 2'b10
        do_write(6'd10, 16'h8A5C);
        do_update();
        lookup(8'd10, d);
        chk(d == 16'h0 && img_valid == 1'b0, "R2 bad signature rejected", {img_valid, d}, 0);
        do_write(6'd10, 16'h4A5C);
        do_update();
        lookup(8'd10, d);
        chk(d == 16'h4A5C && img_valid, "R2 signature restored", {img_valid, d}, {1'b1, 16'h4A5C});

        // R10: update and write requested together -> update first, busy high
        fix = 16'hBABA - sum63();
        @(negedge clk);
        upd_req = 1'b1; wr_req = 1'b1; wr_addr = 6'd20; wr_data = 16'h0F0F;
        @(negedge clk);
        chk(busy == 1'b1, "R10 busy after accept", busy, 1);
        do @(negedge clk); while (!op_done);
        upd_req = 1'b0;
        chk(last_wr == 6'd63 && em[63] == fix, "R10 update has priority", {last_wr, em[63]}, {6'd63, fix});
        do @(negedge clk); while (!op_done);
        wr_req = 1'b0;
        chk(last_wr == 6'd20 && em[20] == 16'h0F0F, "R10 write served next", {last_wr, em[20]}, {6'd20, 16'h0F0F});
        @(negedge clk);
        chk(busy == 1'b0, "R10 idle after done", busy, 0);

        // R3: word 20 changed after the repair -> invalid again
        lookup(8'd20, d);
        chk(d == 16'h0 && img_valid == 1'b0, "R3 stale checksum invalid", {img_valid, d}, 0);
        chk(order_bad == 0, "R1 order over all loads", order_bad, 0);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule